// File: doc/BRIEF.md
# Dual Wiper Register Bank

This block holds the position state of two independent digital potentiometers. Each channel keeps a live 8-bit wiper register, which sets the tap, and four 8-bit preset registers. Presets are modelled as flops whose reset contents are parameters. On reset every channel starts with its wiper equal to its preset 0. The wiper register drives a one-hot tap-switch vector with one bit per tap.

A host issues one-cycle commands on a parallel interface. Each command carries a channel, a register index, an opcode, a data byte and a direction bit. The host can write or read any register, load a preset into the wiper, save the wiper into a preset, and step the wiper one tap up or down. An active-low protect input blocks every write into the presets. While it is low, writes to the wiper still take effect. A blocked write is flagged with a one-cycle error pulse.

Top module: `potbank`

## Requirements
- R1: While reset is held and after it is released, each channel's presets hold their parameter values, and the wiper equals that channel's preset 0. With the default parameters, channel 0 has presets {0x80,0x00,0x10,0xFE} and channel 1 has {0x40,0x01,0x7E,0xC3}, listed from preset 0 to preset 3.
- R2: Opcode 0 (write) with a register index whose bit 2 is 1 writes `cmd_data` into the selected wiper. The new value shows on `wiper_val` from the cycle after the command.
- R3: While `wp_n` is low, the following are ignored: a write (opcode 0) to a preset, and a save (opcode 3). Each one raises `wr_err` for exactly the cycle after the command. A wiper write under protection still takes effect and raises no error.
- R4: Each channel's tap vector has exactly one bit set at all times after reset.
- R5: The set tap bit index equals the wiper value: 0x00 selects bit 0 (low end) and 0xFF selects bit 255 (high end).
- R6: Opcode 1 (read) returns the selected register on `rd_data`, with `rd_valid` high, in the cycle after the command. `rd_valid` is low in every other cycle.
- R7: Opcode 2 (load) copies preset `cmd_reg[1:0]` into the wiper. This requires `cmd_reg[2]`=0.
- R8: Opcode 3 (save) with `cmd_reg[2]`=0 and `wp_n` high copies the wiper into preset `cmd_reg[1:0]`.
- R9: Opcode 4 (step) moves the wiper one tap. It moves up when `cmd_up`=1 and down when `cmd_up`=0.
- R10: A step up at 0xFF or a step down at 0x00 leaves the wiper unchanged.
- R11: `cmd_ch` selects the channel. A command never changes the other channel.

Port bits: the wiper of channel c is `wiper_val[8c+7:8c]`, and its taps are `tap_sel[256c+255:256c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, recalls presets |
| wp_n | input | 1 | Active-low preset write protect |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_ch | input | 1 | Channel select |
| cmd_reg | input | 3 | Register index: bit 2 wiper, else preset [1:0] |
| cmd_op | input | 3 | 0 write, 1 read, 2 load, 3 save, 4 step |
| cmd_data | input | 8 | Write data |
| cmd_up | input | 1 | Step direction, 1 = up |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| wr_err | output | 1 | Blocked preset write pulse |
| wiper_val | output | 16 | Wiper registers, channel 0 in low byte |
| tap_sel | output | 512 | One-hot tap switches, channel 0 in low half |

## Verification
The bench steps into both ends of the range and steps again. A wrapping counter would show up there as a jump from 0xFF to 0x00, or from 0x00 to 0xFF. It drives protected preset writes and saves, then reads the preset back. A design that leaks the write or drops the error pulse fails that check, and so does one that also blocks wiper writes. It checks the tap vector at both end values and at the reset value, which catches an off-by-one or reversed decode. It also checks that commands to one channel leave the other channel's wiper alone.

// File: rtl/potbank_pkg.sv
package potbank_pkg;
   typedef enum logic [2:0] {
      OP_WRITE = 3'd0,
      OP_READ  = 3'd1,
      OP_LOAD  = 3'd2,
      OP_SAVE  = 3'd3,
      OP_STEP  = 3'd4
   } pb_op_e;
endpackage

// File: rtl/potbank_tapdec.sv
module potbank_tapdec #(
   parameter int WW = 8,
   localparam int TAPS = 1 << WW
) (
   input  logic [WW-1:0]   wip,
   output logic [TAPS-1:0] tap
);
   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign tap[t] = (wip == WW'(t));
   end
endmodule

// File: rtl/potbank_chan.sv
module potbank_chan
   import potbank_pkg::*;
#(
   parameter int WW   = 8,
   parameter int NPRE = 4,
   parameter logic [NPRE-1:0][WW-1:0] INIT = '0,
   localparam int IW   = $clog2(NPRE),
   localparam int RW   = IW + 1,
   localparam int TAPS = 1 << WW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wp_n,
   input  logic            sel,
   input  pb_op_e          op,
   input  logic [RW-1:0]   regi,
   input  logic [WW-1:0]   data,
   input  logic            up,
   output logic [WW-1:0]   wip_q,
   output logic [TAPS-1:0] tap,
   output logic [WW-1:0]   rd_val,
   output logic            blocked
);
   localparam logic [WW-1:0] WMAX = '1;

   logic [NPRE-1:0][WW-1:0] pre_q;
   logic [WW-1:0]           wip_d;
   logic [WW-1:0]           pre_wdata;
   logic [IW-1:0]           pidx;
   logic                    is_wip;
   logic                    pre_wr;

   assign is_wip    = regi[RW-1];
   assign pidx      = regi[IW-1:0];
   assign pre_wr    = sel && !is_wip && (op == OP_WRITE || op == OP_SAVE);
   assign pre_wdata = (op == OP_WRITE) ? data : wip_q;
   assign blocked   = pre_wr && !wp_n;
   assign rd_val    = is_wip ? wip_q : pre_q[pidx];

   always_comb begin
      wip_d = wip_q;
      if (sel) begin
         case (op)
            OP_WRITE: if (is_wip) wip_d = data;
            OP_LOAD:  if (!is_wip) wip_d = pre_q[pidx];
            OP_STEP: begin
               if (up && wip_q != WMAX)       wip_d = wip_q + 1'b1;
               else if (!up && wip_q != '0)   wip_d = wip_q - 1'b1;
            end
            default: wip_d = wip_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= INIT;
         wip_q <= INIT[0];
      end else begin
         wip_q <= wip_d;
         if (pre_wr && wp_n) pre_q[pidx] <= pre_wdata;
      end
   end

   potbank_tapdec #(.WW(WW)) u_dec (.wip(wip_q), .tap(tap));

   // R3: protected preset writes leave presets untouched
   p_protect_r3: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |=> $stable(pre_q));
   // R4: exactly one tap on
   p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap) == 1);
   // R5: end taps
   p_low_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wip_q == '0) |-> tap[0]);
   p_high_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wip_q == WMAX) |-> tap[TAPS-1]);
   // R9: step up moves one tap
   p_step_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && op == OP_STEP && up && wip_q != WMAX) |=> (wip_q == $past(wip_q) + 1'b1));
   // R10: saturation at both ends
   p_sat_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && op == OP_STEP && up && wip_q == WMAX) |=> (wip_q == WMAX));
   p_sat_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && op == OP_STEP && !up && wip_q == '0) |=> (wip_q == '0));
   // R11: unselected channel holds its wiper
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> $stable(wip_q));
endmodule

// File: rtl/potbank.sv
module potbank
   import potbank_pkg::*;
#(
   parameter int NCH  = 2,
   parameter int WW   = 8,
   parameter int NPRE = 4,
   parameter logic [NCH-1:0][NPRE-1:0][WW-1:0] PRESET_INIT = 64'hC37E0140_FE100080,
   localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int RW   = $clog2(NPRE) + 1,
   localparam int TAPS = 1 << WW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wp_n,
   input  logic                cmd_valid,
   input  logic [CHW-1:0]      cmd_ch,
   input  logic [RW-1:0]       cmd_reg,
   input  logic [2:0]          cmd_op,
   input  logic [WW-1:0]       cmd_data,
   input  logic                cmd_up,
   output logic                rd_valid,
   output logic [WW-1:0]       rd_data,
   output logic                wr_err,
   output logic [NCH*WW-1:0]   wiper_val,
   output logic [NCH*TAPS-1:0] tap_sel
);
   if (WW < 2 || WW > 10) begin : g_bad_ww
      $error("potbank: WW out of range");
   end
   if (NPRE < 2 || (1 << $clog2(NPRE)) != NPRE) begin : g_bad_npre
      $error("potbank: NPRE must be a power of two, at least 2");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("potbank: NCH must be at least 1");
   end

   pb_op_e             op;
   logic               ch_ok;
   logic [NCH-1:0]     sel;
   logic [NCH-1:0]     blk;
   logic [WW-1:0]      ch_rd [NCH];

   assign op    = pb_op_e'(cmd_op);
   assign ch_ok = int'(cmd_ch) < NCH;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign sel[c] = cmd_valid && (cmd_ch == CHW'(c));
      potbank_chan #(
         .WW(WW), .NPRE(NPRE), .INIT(PRESET_INIT[c])
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wp_n    (wp_n),
         .sel     (sel[c]),
         .op      (op),
         .regi    (cmd_reg),
         .data    (cmd_data),
         .up      (cmd_up),
         .wip_q   (wiper_val[c*WW +: WW]),
         .tap     (tap_sel[c*TAPS +: TAPS]),
         .rd_val  (ch_rd[c]),
         .blocked (blk[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         wr_err   <= 1'b0;
      end else begin
         rd_valid <= cmd_valid && ch_ok && op == OP_READ;
         wr_err   <= |blk;
         if (cmd_valid && ch_ok && op == OP_READ) rd_data <= ch_rd[cmd_ch];
      end
   end

   // R6: read result one cycle after the command, only then
   p_read_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && ch_ok && op == OP_READ) |=> rd_valid);
   p_read_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && op == OP_READ) |=> !rd_valid);
   // R3: error pulse only while protected
   p_err_prot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wp_n) |-> !wr_err);
endmodule

// File: tb/potbank_tb.sv
module potbank_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wp_n = 1'b1;
   logic         cmd_valid = 1'b0;
   logic [0:0]   cmd_ch = '0;
   logic [2:0]   cmd_reg = '0;
   logic [2:0]   cmd_op = '0;
   logic [7:0]   cmd_data = '0;
   logic         cmd_up = 1'b0;
   logic         rd_valid;
   logic [7:0]   rd_data;
   logic         wr_err;
   logic [15:0]  wiper_val;
   logic [511:0] tap_sel;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 0;

   localparam logic [2:0] WIP = 3'b100;

   always #5 clk = ~clk;

   potbank u_dut (
      .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
      .cmd_ch(cmd_ch), .cmd_reg(cmd_reg), .cmd_op(cmd_op),
      .cmd_data(cmd_data), .cmd_up(cmd_up), .rd_valid(rd_valid),
      .rd_data(rd_data), .wr_err(wr_err), .wiper_val(wiper_val),
      .tap_sel(tap_sel)
   );

   task automatic check(string req, int got, int exp);
      n_checks++;
      if (got != exp) begin
         n_errs++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   function automatic int wip(int ch);
      return int'(wiper_val[ch*8 +: 8]);
   endfunction

   // returns tap index if exactly one set, else -1
   function automatic int tap_idx(int ch);
      int cnt = 0;
      int pos = -1;
      for (int i = 0; i < 256; i++) begin
         if (tap_sel[ch*256 + i]) begin
            cnt++;
            pos = i;
         end
      end
      return (cnt == 1) ? pos : -1;
   endfunction

   task automatic send(int ch, logic [2:0] rg, logic [2:0] op, logic [7:0] d, logic up);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_ch = ch[0]; cmd_reg = rg; cmd_op = op;
      cmd_data = d; cmd_up = up;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic read_chk(string req, int ch, logic [2:0] rg, int exp);
      send(ch, rg, 3'd1, 8'h00, 1'b0);
      check({req, " rd_valid"}, int'(rd_valid), 1);
      check({req, " rd_data"}, int'(rd_data), exp);
   endtask

   task automatic t_reset;
      check("R1 wiper ch0", wip(0), 'h80);
      check("R1 wiper ch1", wip(1), 'h40);
      check("R4/R5 tap ch0", tap_idx(0), 'h80);
      check("R4/R5 tap ch1", tap_idx(1), 'h40);
      check("R6 rd_valid idle", int'(rd_valid), 0);
      read_chk("R1 ch1 preset3", 1, 3'd3, 'hC3);
      read_chk("R1 ch0 preset2", 0, 3'd2, 'h10);
   endtask

   task automatic t_write_read;
      send(0, WIP, 3'd0, 8'h00, 1'b0);
      check("R2 wiper write ch0", wip(0), 'h00);
      check("R11 ch1 untouched", wip(1), 'h40);
      check("R5 low end tap", tap_idx(0), 0);
      send(0, WIP, 3'd0, 8'hFF, 1'b0);
      check("R5 high end tap", tap_idx(0), 255);
      read_chk("R6 read wiper", 0, WIP, 'hFF);
      @(negedge clk);
      check("R6 rd_valid drops", int'(rd_valid), 0);
   endtask

   task automatic t_step;
      send(0, WIP, 3'd0, 8'hFE, 1'b0);
      send(0, WIP, 3'd4, 8'h00, 1'b1);
      check("R9 step up", wip(0), 'hFF);
      send(0, WIP, 3'd4, 8'h00, 1'b1);
      check("R10 saturate high", wip(0), 'hFF);
      send(0, WIP, 3'd0, 8'h01, 1'b0);
      send(0, WIP, 3'd4, 8'h00, 1'b0);
      check("R9 step down", wip(0), 'h00);
      send(0, WIP, 3'd4, 8'h00, 1'b0);
      check("R10 saturate low", wip(0), 'h00);
      check("R4 tap after saturate", tap_idx(0), 0);
      send(1, WIP, 3'd4, 8'h00, 1'b1);
      check("R11 step ch1", wip(1), 'h41);
      check("R11 ch0 unchanged", wip(0), 'h00);
   endtask

   task automatic t_transfer;
      send(1, 3'd2, 3'd2, 8'h00, 1'b0);
      check("R7 load preset2", wip(1), 'h7E);
      send(1, WIP, 3'd0, 8'h33, 1'b0);
      send(1, 3'd1, 3'd3, 8'h00, 1'b0);
      check("R8 save no error", int'(wr_err), 0);
      read_chk("R8 saved preset1", 1, 3'd1, 'h33);
   endtask

   task automatic t_protect;
      wp_n = 1'b0;
      send(0, 3'd0, 3'd0, 8'h55, 1'b0);
      check("R3 err on preset write", int'(wr_err), 1);
      @(negedge clk);
      check("R3 err one cycle", int'(wr_err), 0);
      read_chk("R3 preset0 kept", 0, 3'd0, 'h80);
      send(0, 3'd3, 3'd3, 8'h00, 1'b0);
      check("R3 err on save", int'(wr_err), 1);
      read_chk("R3 preset3 kept", 0, 3'd3, 'hFE);
      send(0, WIP, 3'd0, 8'h21, 1'b0);
      check("R3 wiper write proceeds", wip(0), 'h21);
      check("R3 no err on wiper write", int'(wr_err), 0);
      wp_n = 1'b1;
      send(0, 3'd0, 3'd0, 8'h55, 1'b0);
      check("R3 unprotected no err", int'(wr_err), 0);
      send(0, 3'd0, 3'd2, 8'h00, 1'b0);
      check("R7 load written preset0", wip(0), 'h55);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 wiper during reset", wip(0), 'h80);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_read();
      t_step();
      t_transfer();
      t_protect();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end
endmodule